// File: doc/BRIEF.md
# Serial Key-Schedule Constant Sequencer

This block feeds the key-schedule stage of a 128-bit-key ARX block cipher. The key-schedule stage has a single shared adder and processes one key word per clock. In each round it needs four rotated copies of one 32-bit schedule constant. The sequencer supplies them one at a time, with one copy per `step_i` pulse. Round `i` uses constant `d = delta[i mod 4]`. Within the round it delivers `d` rotated left by `i`, then by `i+1`, then by `i+2`, then by `i+3`.

Four word registers hold the constants. The head register drives the output. A two-way select in front of the head picks either the chain (at a round boundary) or the head's own value (within a round). A single one-bit left rotator sits after that select. Each chain register also rotates left by one as it shifts. The value leaving the head re-enters the tail rotated right by two, and this exactly cancels the extra rotation it gathers on its way back. A controller pulses `init_i` once per block, then `round_start_i` at each new round, and `step_i` three times inside each round.

Top module: `ks_const_seq`

## Requirements
- R1: After reset, `const_o` equals delta0 = 0xC3EFE9DB, and the sequence stands at round 0, position 0.
- R2: `init_i` restarts the sequence at any time. In the next cycle `const_o` = delta0, and later rounds continue as round 1, 2, and so on.
- R3: `step_i` without `init_i` or `round_start_i` makes `const_o` in the next cycle equal to its previous value rotated left by one.
- R4: The `k`-th `round_start_i` pulse after init or reset starts round `i = k`. In the next cycle `const_o` = ROL_i(delta[i mod 4]).
- R5: When each round has exactly three steps, the value at position `j` (0..3) of round `i` is ROL_{(i+j) mod 32}(delta[i mod 4]). This holds for rounds 0 to 23 and for later rounds as well. The constants are delta0 = 0xC3EFE9DB, delta1 = 0x44626B02, delta2 = 0x79E27C8A and delta3 = 0x78DF30EC.
- R6: A cycle with no strobe leaves `const_o` unchanged, and the chain registers only move on a round start.
- R7: Priority is `init_i` over `round_start_i` over `step_i`. A round start that arrives together with a step acts as a round start alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Restart at round 0 |
| round_start_i | input | 1 | Begin the next round |
| step_i | input | 1 | Advance to the next rotation within a round |
| const_o | output | 32 | Current rotated constant |

## Verification
The bench uses the default parameters: a 32-bit word, a chain of four constants, and the four standard constant values. With these defaults the feedback rotation is two positions right. The bench runs forty rounds, so the rotation amount wraps past 31 and the constant index cycles ten times. It inserts random idle gaps between the steps. It then exercises a restart in the middle of a round and strobes that arrive together.

// File: rtl/ks_const_pkg.sv
`timescale 1ns/1ps
package ks_const_pkg;
  localparam int unsigned WORD_W_DEF  = 32;
  localparam int unsigned N_CONST_DEF = 4;
  localparam logic [N_CONST_DEF-1:0][WORD_W_DEF-1:0] DELTA_DEF =
    {32'h78DF30EC, 32'h79E27C8A, 32'h44626B02, 32'hC3EFE9DB};

  typedef enum logic [1:0] {
    HEAD_HOLD = 2'd0,
    HEAD_LOAD = 2'd1,
    HEAD_STEP = 2'd2,
    HEAD_INIT = 2'd3
  } head_sel_e;
endpackage

// File: rtl/ks_const_chain.sv
`timescale 1ns/1ps
module ks_const_chain #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_CONST = 4,
  parameter logic [N_CONST-1:0][WORD_W-1:0] DELTA_INIT = ks_const_pkg::DELTA_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] recycle_i,
  output logic [WORD_W-1:0] next_o
);
  // hops back to head each add one left rotation; cancel all but one
  localparam int unsigned FB_ROT = N_CONST - 2;

  logic [N_CONST-1:1][WORD_W-1:0] c_q;
  logic [N_CONST-1:1][WORD_W-1:0] c_d;

  for (genvar k = 1; k < N_CONST; k++) begin : g_stage
    if (k == N_CONST - 1) begin : g_tail
      assign c_d[k] = (recycle_i >> FB_ROT) | (recycle_i << (WORD_W - FB_ROT));
    end else begin : g_mid
      assign c_d[k] = {c_q[k+1][WORD_W-2:0], c_q[k+1][WORD_W-1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      c_q[k] <= DELTA_INIT[k];
      else if (init_i)  c_q[k] <= DELTA_INIT[k];
      else if (shift_i) c_q[k] <= c_d[k];
    end
  end

  assign next_o = c_q[1];

  a_r6_chain_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !init_i) |=> $stable(c_q));

  a_r5_recycle_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !init_i) |=>
      (((c_q[N_CONST-1] << FB_ROT) | (c_q[N_CONST-1] >> (WORD_W - FB_ROT))) == $past(recycle_i)));
endmodule

// File: rtl/ks_const_head.sv
`timescale 1ns/1ps
module ks_const_head #(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-1:0] SEED = 32'hC3EFE9DB
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  ks_const_pkg::head_sel_e   sel_i,
  input  logic [WORD_W-1:0]         chain_i,
  output logic [WORD_W-1:0]         head_o
);
  import ks_const_pkg::*;

  logic [WORD_W-1:0] head_q, src, rot;

  // one shared rotator behind the two-way select
  assign src = (sel_i == HEAD_LOAD) ? chain_i : head_q;
  assign rot = {src[WORD_W-2:0], src[WORD_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_q <= SEED;
    else begin
      unique case (sel_i)
        HEAD_INIT:            head_q <= SEED;
        HEAD_LOAD, HEAD_STEP: head_q <= rot;
        default:              head_q <= head_q;
      endcase
    end
  end

  assign head_o = head_q;

  a_r3_step_rotates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == HEAD_STEP) |=>
      (head_q == {$past(head_q[WORD_W-2:0]), $past(head_q[WORD_W-1])}));

  a_r6_head_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == HEAD_HOLD) |=> $stable(head_q));

  a_r2_init_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == HEAD_INIT) |=> (head_q == SEED));
endmodule

// File: rtl/ks_const_seq.sv
`timescale 1ns/1ps
module ks_const_seq #(
  parameter int unsigned WORD_W  = ks_const_pkg::WORD_W_DEF,
  parameter int unsigned N_CONST = ks_const_pkg::N_CONST_DEF,
  parameter logic [N_CONST-1:0][WORD_W-1:0] DELTA_INIT = ks_const_pkg::DELTA_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              round_start_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] const_o
);
  import ks_const_pkg::*;

  head_sel_e         sel;
  logic [WORD_W-1:0] chain_next;
  logic [WORD_W-1:0] head;

  always_comb begin
    if (init_i)             sel = HEAD_INIT;
    else if (round_start_i) sel = HEAD_LOAD;
    else if (step_i)        sel = HEAD_STEP;
    else                    sel = HEAD_HOLD;
  end

  ks_const_chain #(
    .WORD_W(WORD_W), .N_CONST(N_CONST), .DELTA_INIT(DELTA_INIT)
  ) i_chain (
    .clk_i, .rst_ni,
    .init_i,
    .shift_i  (sel == HEAD_LOAD),
    .recycle_i(head),
    .next_o   (chain_next)
  );

  ks_const_head #(
    .WORD_W(WORD_W), .SEED(DELTA_INIT[0])
  ) i_head (
    .clk_i, .rst_ni,
    .sel_i  (sel),
    .chain_i(chain_next),
    .head_o (head)
  );

  assign const_o = head;

  a_r4_round_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (round_start_i && !init_i) |=>
      (const_o == {$past(chain_next[WORD_W-2:0]), $past(chain_next[WORD_W-1])}));

  a_r7_init_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (const_o == DELTA_INIT[0]));
endmodule

// File: tb/test_ks_const_seq.sv
`timescale 1ns/1ps
module test_ks_const_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0, round_start_i = 1'b0, step_i = 1'b0;
  logic [31:0] const_o;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ks_const_seq i_ks_const_seq (
    .clk_i(clk), .rst_ni, .init_i, .round_start_i, .step_i, .const_o
  );

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    int m = n % 32;
    return (x << m) | (x >> (32 - m));
  endfunction

  function automatic logic [31:0] delta(input int idx);
    case (idx % 4)
      0: return 32'hC3EFE9DB;
      1: return 32'h44626B02;
      2: return 32'h79E27C8A;
      default: return 32'h78DF30EC;
    endcase
  endfunction

  function automatic logic [31:0] exp_val(input int rnd, input int j);
    return rotl(delta(rnd), rnd + j);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic ini, input logic rs, input logic st);
    init_i = ini; round_start_i = rs; step_i = st;
    tick();
    init_i = 1'b0; round_start_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic run_rounds(input int first, input int last);
    for (int r = first; r <= last; r++) begin
      if (r != first) pulse(1'b0, 1'b1, 1'b0);
      check("R4", const_o, exp_val(r, 0));
      for (int j = 1; j < 4; j++) begin
        int idle = $urandom_range(0, 2);
        for (int k = 0; k < idle; k++) begin
          tick();
          check("R6", const_o, exp_val(r, j - 1));
        end
        pulse(1'b0, 1'b0, 1'b1);
        check("R3/R5", const_o, exp_val(r, j));
      end
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd90210));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", const_o, 32'hC3EFE9DB);

    // R5: full schedule, beyond 24 rounds so rotation and index wrap
    run_rounds(0, 39);

    // R2: restart in the middle of a round
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    check("R2", const_o, 32'hC3EFE9DB);
    run_rounds(0, 5);

    // R7: round start with step acts as round start
    pulse(1'b0, 1'b1, 1'b1);
    check("R7", const_o, exp_val(6, 0));
    pulse(1'b0, 1'b0, 1'b1);
    check("R7", const_o, exp_val(6, 1));

    // R7: init beats everything
    pulse(1'b1, 1'b1, 1'b1);
    check("R7", const_o, 32'hC3EFE9DB);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    check("R2", const_o, exp_val(1, 0));

    // R6: long idle
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R6", const_o, exp_val(1, 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule